// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block holds the per-line configuration of a general purpose I/O port that is split into banks of equal width. Each bank owns two registers on a simple 32-bit register bus: a level register, whose stored value is driven onto the pads of lines configured as outputs, and a mode register, which chooses for each line whether it is an input or an output. The controller drives the pad output value and the pad output enable for every line. It samples every pad through a two-stage synchronizer so that reads return a clean level.

Bank register pairs sit at a regular stride. A fixed window of the address space is left for interrupt control logic that lives elsewhere, so the address map steps over that window and every bank beyond it is displaced. A read of any address that holds no register returns zero. A write to such an address changes nothing. Software switches a line to output by first writing the level and then clearing the mode bit, so the pad never drives a stale value.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every mode bit is 1 (input), every level register is 0, pad_oe and pad_out are all 0, and bus_rdata is 0.
- R2: Bank n (counted from 0) has a base address of (n+1)*8 before the hole correction. Its level register is at base+0x0 and its mode register is at base+0x4. At most one register is selected by any address.
- R3: A bank whose uncorrected base is 0x90 or higher is moved up by 0x10, so no register lives in 0x90 to 0x9F. With 8-line banks, bank 16 is at 0x88, bank 17 at 0xA0 and bank 18 at 0xA8.
- R4: A write takes effect at the next clock edge. Only bus_wdata bits [LINES_PER_BANK-1:0] are stored, and register bits above the line count read as 0.
- R5: A mode bit of 1 makes the line an input (pad_oe bit 0). A mode bit of 0 makes it an output (pad_oe bit 1). pad_out always shows the level register.
- R6: A read of a level register returns, for each line, the synchronized pad level if the line is an input and the stored level if it is an output. A read of a mode register returns the mode bits.
- R7: A pad change is seen by a read that samples the bus two clock edges after the change is first captured. A read that samples one edge after it still returns the old level.
- R8: bus_rdata is registered. It is loaded at the clock edge where bus_rd is sampled high and holds its value while bus_rd is low.
- R9: Reads of unmapped addresses return 0, and writes to them leave all state unchanged. Unmapped addresses are the hole, addresses below 0x08, addresses past the last bank, and any address that does not match a register exactly (for example misaligned ones).
- R10: Writing a mode register does not change the level register. A level written while the line is an input appears on pad_out in the first cycle pad_oe is raised.
- R11: When bus_rd and bus_wr target the same register in the same cycle, the read returns the value held before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_BANKS*LINES_PER_BANK | Asynchronous pad input levels |
| pad_out | output | NUM_BANKS*LINES_PER_BANK | Level driven toward the pads |
| pad_oe | output | NUM_BANKS*LINES_PER_BANK | Pad output enable, 1 = drive |

## Verification
The assertions assume that the strobes and the address are stable across each sampling edge and that reset is held for at least two edges, so the synchronizer chain starts from a known state. The bench drives every bus input on the falling edge and asserts reset for several cycles. Readback checks of input lines take the pad as settled, so in the random phase every pad change is followed by two idle edges before the next access. The latency at that boundary is checked separately in a directed case.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and address-map helper for the banked GPIO
// controller. Assumes bank strides are a power-of-two multiple of 4 bytes.
package gpio_bank_pkg;

    localparam int unsigned REG_W = 32;

    typedef enum logic [0:0] {
        SEL_LEVEL = 1'b0,
        SEL_MODE  = 1'b1
    } gpio_reg_e;

    // Byte address of a bank window, stepping over the reserved hole.
    function automatic int unsigned bank_window(
        input int unsigned idx,
        input int unsigned stride,
        input int unsigned hole_base,
        input int unsigned hole_size
    );
        int unsigned base;
        base = (idx + 1) * stride;
        if (base >= hole_base) begin
            base = base + hole_size;
        end
        return base;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Turns a bus byte address into a one-hot bank select and a register kind.
// Assumes every bank window, including the hole shift, fits in ADDR_W bits.
// clk and rst_n are used only by the assertions.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 20,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned STRIDE      = 8,
    parameter int unsigned MODE_OFFSET = 4,
    parameter int unsigned HOLE_BASE   = 'h90,
    parameter int unsigned HOLE_SIZE   = 'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_sel,
    output gpio_reg_e            reg_kind,
    output logic                 hit
);

    localparam int unsigned HOLE_END = HOLE_BASE + HOLE_SIZE;

    // Compare the address against every bank's level and mode location.
    always_comb begin
        bank_sel = '0;
        reg_kind = SEL_LEVEL;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(bank_window(b, STRIDE, HOLE_BASE, HOLE_SIZE))) begin
                bank_sel[b] = 1'b1;
            end else if (addr == ADDR_W'(bank_window(b, STRIDE, HOLE_BASE, HOLE_SIZE)
                                         + MODE_OFFSET)) begin
                bank_sel[b] = 1'b1;
                reg_kind    = SEL_MODE;
            end
        end
    end

    // A hit is any bank selected.
    assign hit = |bank_sel;

    // R2: no address selects two banks.
    p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    // R3: the interrupt hole never decodes to a register.
    always_comb begin
        if (32'(addr) >= HOLE_BASE && 32'(addr) < HOLE_END) begin
            p_hole_unmapped_r3: assert (!hit);
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchronizer for asynchronous pad inputs. Assumes each bit is
// sampled on its own and that no multi-bit coherence is needed.
module gpio_in_sync #(
    parameter int unsigned WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    // Capture the pads, then retime once more to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

    // R7: the second stage follows the first one edge later.
    p_sync_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out == $past(stage1));

endmodule

// File: rtl/gpio_bank_regs.sv
// Module: gpio_bank_regs
// Level and mode registers for one bank. Assumes at most one of the two
// write enables is high in a cycle (the decoder guarantees this).
module gpio_bank_regs #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_level,
    input  logic             wr_mode,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] level_q,
    output logic [LINES-1:0] mode_q
);

    // Level register: cleared at reset, loaded by its own write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (wr_level) begin
            level_q <= wdata;
        end
    end

    // Mode register: all inputs at reset, loaded by its own write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '1;
        end else if (wr_mode) begin
            mode_q <= wdata;
        end
    end

    // R4: a level write lands at the next edge.
    p_level_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_level |=> level_q == $past(wdata));

    // R9: without a level write the level register holds.
    p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_level |=> $stable(level_q));

    // R10: a mode write leaves the level register alone.
    p_mode_keeps_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !wr_level) |=> $stable(level_q));

    // R9: without a mode write the mode register holds.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: gpio_bank_ctrl (top)
// Banked GPIO register controller: address decode, per-bank level and mode
// registers, pad drive and synchronized readback. Assumes single-cycle
// strobes with the address stable across the sampling edge.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_BANKS      = 20,
    parameter int unsigned LINES_PER_BANK = 8,
    parameter int unsigned ADDR_W         = 8,
    parameter int unsigned BANK_STRIDE    = 8,
    parameter int unsigned MODE_OFFSET    = 4,
    parameter int unsigned HOLE_BASE      = 'h90,
    parameter int unsigned HOLE_SIZE      = 'h10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] pad_in,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] pad_out,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] pad_oe
);

    localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    logic [NUM_BANKS-1:0]                     bank_sel;
    gpio_reg_e                                reg_kind;
    logic                                     hit;
    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] level_all;
    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] mode_all;
    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] sync_all;
    logic [LINES_PER_BANK-1:0]                rd_val;
    logic                                     wdata_unused;

    // Upper write-data bits have no storage behind them.
    assign wdata_unused = ^bus_wdata[31:LINES_PER_BANK];

    gpio_addr_decode #(
        .NUM_BANKS  (NUM_BANKS),
        .ADDR_W     (ADDR_W),
        .STRIDE     (BANK_STRIDE),
        .MODE_OFFSET(MODE_OFFSET),
        .HOLE_BASE  (HOLE_BASE),
        .HOLE_SIZE  (HOLE_SIZE)
    ) i_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .bank_sel(bank_sel),
        .reg_kind(reg_kind),
        .hit     (hit)
    );

    gpio_in_sync #(
        .WIDTH(NUM_LINES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(sync_all)
    );

    // One register pair per bank, each gated by its own select.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_lvl;
        logic wr_md;

        // Route the write strobe to the level or mode register of bank b.
        assign wr_lvl = bus_wr && bank_sel[b] && (reg_kind == SEL_LEVEL);
        assign wr_md  = bus_wr && bank_sel[b] && (reg_kind == SEL_MODE);

        gpio_bank_regs #(
            .LINES(LINES_PER_BANK)
        ) i_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_level(wr_lvl),
            .wr_mode (wr_md),
            .wdata   (bus_wdata[LINES_PER_BANK-1:0]),
            .level_q (level_all[b]),
            .mode_q  (mode_all[b])
        );
    end

    // Pads drive the stored level; a mode bit of 0 enables the driver.
    assign pad_out = level_all;
    assign pad_oe  = ~mode_all;

    // Pick the addressed register; level reads merge pads and drive values.
    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel[b]) begin
                if (reg_kind == SEL_MODE) begin
                    rd_val = mode_all[b];
                end else begin
                    rd_val = (mode_all[b] & sync_all[b]) | (~mode_all[b] & level_all[b]);
                end
            end
        end
    end

    // Register the read word on each read strobe; unmapped reads give 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= hit ? REG_W'(rd_val) : '0;
        end
    end

    // R8: read data holds between read strobes.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9: an unmapped read returns zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> bus_rdata == '0);

    // R1: coming out of reset no line is driven.
    p_reset_inputs_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (pad_oe == '0 && pad_out == '0));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

    localparam int NB = 20;
    localparam int L  = 8;
    localparam int N  = NB * L;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;

    int checks = 0;
    int errors = 0;

    logic [L-1:0] m_level [NB];
    logic [L-1:0] m_mode  [NB];

    always #2 clk = ~clk;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    function automatic logic [7:0] addr_of(int b, bit mode);
        int base = (b + 1) * 8;
        if (base >= 'h90) base += 'h10;
        return 8'(base + (mode ? 4 : 0));
    endfunction

    function automatic logic [31:0] exp_read(int b, bit mode);
        logic [L-1:0] v;
        if (mode) v = m_mode[b];
        else v = (m_mode[b] & pad_in[b*L +: L]) | (~m_mode[b] & m_level[b]);
        return 32'(v);
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_pads(string req);
        logic [N-1:0] eo, ee;
        for (int b = 0; b < NB; b++) begin
            eo[b*L +: L] = m_level[b];
            ee[b*L +: L] = ~m_mode[b];
        end
        chk({req, " pad_out"}, pad_out, eo);
        chk({req, " pad_oe"}, pad_oe, ee);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic bus_rw(logic [7:0] a, logic [31:0] d, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wr_reg(int b, bit mode, logic [31:0] d);
        bus_write(addr_of(b, mode), d);
        if (mode) m_mode[b] = d[L-1:0];
        else m_level[b] = d[L-1:0];
    endtask

    task automatic set_pads(logic [N-1:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(string req, int b, bit mode);
        logic [31:0] v;
        bus_read(addr_of(b, mode), v);
        chk(req, N'(v), N'(exp_read(b, mode)));
    endtask

    initial begin
        logic [31:0] v, v2;
        logic [7:0] bad [8];
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < NB; b++) begin
            m_level[b] = '0;
            m_mode[b]  = '1;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", N'(bus_rdata), '0);
        chk_pads("R1");
        for (int b = 0; b < NB; b++) begin
            rd_chk("R1 mode reset", b, 1'b1);
            rd_chk("R1 level reset", b, 1'b0);
        end

        // R2 address map: distinct values per bank read back
        for (int b = 0; b < NB; b++) wr_reg(b, 1'b0, 32'(b * 7 + 3));
        for (int b = 0; b < NB; b += 2) wr_reg(b, 1'b1, 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd_chk("R2 level", b, 1'b0);
            rd_chk("R2 mode", b, 1'b1);
        end
        chk_pads("R2/R5");

        // R3 hole and shifted banks
        bus_read(8'h88, v); chk("R3 bank16 at 0x88", N'(v), N'(exp_read(16, 1'b0)));
        bus_read(8'hA0, v); chk("R3 bank17 at 0xA0", N'(v), N'(exp_read(17, 1'b0)));
        bus_read(8'hA8, v); chk("R3 bank18 at 0xA8", N'(v), N'(exp_read(18, 1'b0)));
        for (int a = 'h90; a < 'hA0; a += 4) begin
            bus_read(8'(a), v); chk("R3 hole read", N'(v), '0);
        end

        // R9 unmapped writes ignored, reads zero
        bad[0] = 8'h90; bad[1] = 8'h94; bad[2] = 8'h98; bad[3] = 8'h9C;
        bad[4] = 8'h00; bad[5] = 8'h09; bad[6] = 8'hB8; bad[7] = 8'hFC;
        for (int i = 0; i < 8; i++) bus_write(bad[i], 32'hFFFF_FFFF);
        chk_pads("R9 after unmapped writes");
        for (int i = 0; i < 8; i++) begin
            bus_read(bad[i], v); chk("R9 unmapped read", N'(v), '0);
        end
        for (int b = 15; b < NB; b++) rd_chk("R9 neighbours intact", b, 1'b1);

        // R4 upper bits dropped
        wr_reg(5, 1'b1, 32'hFFFF_FF00);
        wr_reg(5, 1'b0, 32'hFFFF_FFFF);
        bus_read(addr_of(5, 1'b0), v); chk("R4 upper bits zero", N'(v), N'(32'h0000_00FF));
        bus_read(addr_of(5, 1'b1), v); chk("R4 mode upper zero", N'(v), N'(32'h0));

        // R10 level first, then mode clear
        wr_reg(3, 1'b1, 32'hFF);
        wr_reg(3, 1'b0, 32'hA5);
        chk_pads("R10 held while input");
        wr_reg(3, 1'b1, 32'h00);
        chk("R10 oe on", N'(pad_oe[3*L +: L]), N'(8'hFF));
        chk("R10 out value", N'(pad_out[3*L +: L]), N'(8'hA5));
        rd_chk("R10 level kept", 3, 1'b0);

        // R6 mixed input/output readback
        wr_reg(7, 1'b1, 32'hF0);
        wr_reg(7, 1'b0, 32'h3C);
        set_pads(N'(1) << (7*L) | N'(8'hC3) << (7*L));
        rd_chk("R6 mixed lines", 7, 1'b0);

        // R7 synchronizer latency, R8 hold
        wr_reg(0, 1'b1, 32'hFF);
        set_pads(pad_in & ~N'(8'hFF));
        @(negedge clk);
        pad_in[7:0] = 8'h5A;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = addr_of(0, 1'b0);
        @(negedge clk);
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        v2 = bus_rdata;
        chk("R7 one edge old", N'(v), N'(0));
        chk("R7 two edges new", N'(v2), N'(32'h5A));
        repeat (3) @(negedge clk);
        chk("R8 rdata held", N'(bus_rdata), N'(32'h5A));

        // R11 read/write collision
        wr_reg(9, 1'b1, 32'h00);
        wr_reg(9, 1'b0, 32'h11);
        bus_rw(addr_of(9, 1'b0), 32'h66, v);
        m_level[9] = 8'h66;
        chk("R11 old value", N'(v), N'(32'h11));
        rd_chk("R11 write landed", 9, 1'b0);

        // Random phase: R2 R4 R5 R6
        for (int it = 0; it < 500; it++) begin
            int op = $urandom_range(0, 4);
            int b = $urandom_range(0, NB - 1);
            case (op)
                0: begin wr_reg(b, 1'b0, $urandom()); chk_pads("R5 random level"); end
                1: begin wr_reg(b, 1'b1, $urandom()); chk_pads("R5 random mode"); end
                2: set_pads({$urandom(), $urandom(), $urandom(), $urandom(), $urandom()});
                3: rd_chk("R6 random level read", b, 1'b0);
                default: rd_chk("R2 random mode read", b, 1'b1);
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule